// File: doc/BRIEF.md
# Round-Robin Serial ADC Sampler

This block is a cut-down SPI master that keeps polling a set of external serial analog-to-digital converters, one channel after another, and parks each finished conversion in that channel's own 16-bit result register. Every converter shares one serial data return line. The chip-select pins tell the board which converter (or which input of a quad converter) is being read. A mode input picks one of three framings, and each framing fixes the sample width, how many channels a pass covers and what the select pins carry.

After reset the block sits idle. When `enable` goes high it starts a pass at channel 0. It runs each frame with a divided serial clock and writes the result when the frame ends. A single idle cycle separates one frame from the next, and when the last channel is written a one-cycle `round_done` pulse marks the end of the pass. While `enable` stays high, passes follow each other with no break. The results are plain registers that are always readable. There is no handshake on them: a value simply stays until the same channel's next frame completes.

Top module: `rr_adc_sampler`

## Requirements
- R1: After reset, `sel_en_n` is 1, `sclk` is 0, `sel` is 0, `round_done` is 0 and every result register reads 0.
- R2: Channels are read in ascending order. A pass started from idle begins at channel 0. `sel` holds the channel number for the whole frame, and only the bits shifted in during that frame reach that channel's register.
- R3: With `mode` = 2 (and 3, which behaves the same), each frame is 16 bits, a pass covers channels 0 to 7, and `sel` carries the 3-bit channel code for an external 3:8 active-low decoder.
- R4: With `mode` = 1, each frame is 15 bits, a pass covers channels 0 to 7, and the result is right-aligned and zero-extended to 16 bits.
- R5: With `mode` = 0, each frame is 12 bits and a pass covers channels 0 to 3 only. `sel[1:0]` carries the channel index and `sel[2]` stays 0. Result registers 4 to 7 keep their earlier contents.
- R6: `sclk` is the block clock divided by `CLK_DIV` (even), idles low, and shows exactly as many rising edges per frame as the frame has bits. Data is taken MSB first on each rising edge.
- R7: A result register changes only in the cycle its frame completes. During a frame it still holds the previous value.
- R8: `round_done` is high for exactly one cycle, starting with the cycle in which the last channel's result of a pass becomes visible.
- R9: When `enable` drops in the middle of a frame, that frame still finishes and stores its result. After that, `sel_en_n` stays 1, `sclk` stays 0 and `sel` returns to 0.
- R10: `mode` is sampled only when a pass begins. A change in the middle of a pass takes effect from the next pass.
- R11: Between two frames of a running pass, `sel_en_n` is high for exactly one block-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| enable | input | 1 | Run request; sampling continues while high |
| mode | input | 2 | Framing select: 0 = 12-bit quad, 1 = 15-bit, 2/3 = 16-bit |
| miso | input | 1 | Shared serial data from all converters |
| sclk | output | 1 | Serial clock, idle low |
| sel | output | 3 | Channel code on the select pins |
| sel_en_n | output | 1 | Active-low frame strobe (decoder enable / chip select) |
| result_flat | output | 128 | Eight 16-bit result registers, channel n at bits [16n+15:16n] |
| round_done | output | 1 | One-cycle pulse at the end of every pass |

## Verification
The hardest cases to reach are events that fall inside a pass rather than between passes: `enable` dropping partway through a frame, and `mode` changing after the first frame of a pass has already finished. The bench includes a converter model that follows `sel_en_n` and `sclk`, so it can tie each stimulus to edges it has seen. It waits for the start of a frame plus a fixed number of cycles before dropping `enable`, and it waits for the first rising edge of `sel_en_n` before changing `mode`. It then counts frames and clock rises to confirm that the running frame and the running pass kept their original framing.

// File: rtl/rr_sampler_pkg.sv
package rr_sampler_pkg;

  typedef enum logic [1:0] {
    FMT_QUAD12 = 2'd0,
    FMT_SOLO15 = 2'd1,
    FMT_SOLO16 = 2'd2,
    FMT_WIDE16 = 2'd3
  } frame_fmt_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XFER = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_t;

  localparam int unsigned QUAD_BITS   = 12;
  localparam int unsigned SOLO15_BITS = 15;
  localparam int unsigned SOLO16_BITS = 16;
  localparam int unsigned BITCNT_W    = 5;
  localparam int unsigned QUAD_CHANS  = 4;

  function automatic logic [BITCNT_W-1:0] fmt_bits(input frame_fmt_t f);
    case (f)
      FMT_QUAD12: return BITCNT_W'(QUAD_BITS);
      FMT_SOLO15: return BITCNT_W'(SOLO15_BITS);
      default:    return BITCNT_W'(SOLO16_BITS);
    endcase
  endfunction

  function automatic logic fmt_is_quad(input frame_fmt_t f);
    return f == FMT_QUAD12;
  endfunction

endpackage

// File: rtl/rr_sclk_div.sv
module rr_sclk_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt;

  assign rise_tick = run && (cnt == CNT_W'(HALF - 1));
  assign fall_tick = run && (cnt == CNT_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + CNT_W'(1);
      if (rise_tick)      sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
    end
  end

  // R6: the serial clock is only ever high inside a frame
  p_sclk_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> run);
  // R6: a rising tick always starts from a low serial clock
  p_rise_from_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> !sclk);
  // R6: a falling tick always starts from a high serial clock
  p_fall_from_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> sclk);

endmodule

// File: rtl/rr_frame_shift.sv
module rr_frame_shift #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              din,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)     word <= '0;
    else if (clear) word <= '0;
    else if (take)  word <= {word[DATA_W-2:0], din};
  end

  // R6: bits enter only while a frame runs, never in the cleared state
  p_no_take_when_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (word == '0));

endmodule

// File: rtl/rr_result_bank.sv
module rr_result_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*DATA_W-1:0] result_flat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [DATA_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (!rst_n) slot <= '0;
      else if (wr_en && (wr_addr == SEL_W'(g))) slot <= wr_data;
    end
    assign result_flat[g*DATA_W +: DATA_W] = slot;
  end

  // R2: writes only ever target an existing channel
  p_write_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NUM_CH));
  // R7: with no write strobe the whole bank holds
  p_bank_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(result_flat));

endmodule

// File: rtl/rr_channel_seq.sv
module rr_channel_seq
  import rr_sampler_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic             fall_tick,
  output logic             run,
  output logic [SEL_W-1:0] sel,
  output logic             sel_en_n,
  output logic             wr_en,
  output logic [SEL_W-1:0] wr_addr,
  output logic             round_done
);
  localparam int unsigned LAST_SOLO = NUM_CH - 1;
  localparam int unsigned LAST_QUAD = (NUM_CH < QUAD_CHANS) ? NUM_CH - 1 : QUAD_CHANS - 1;

  seq_state_t           state;
  frame_fmt_t           fmt_q;
  logic [SEL_W-1:0]     ch_q;
  logic [BITCNT_W-1:0]  bit_q;
  logic                 done_q;

  logic [SEL_W-1:0]     last_ch;
  logic [SEL_W-1:0]     ch_next;
  logic [BITCNT_W-1:0]  frame_bits;
  logic                 last_bit;
  logic                 frame_end;
  logic                 wrap;

  assign last_ch    = fmt_is_quad(fmt_q) ? SEL_W'(LAST_QUAD) : SEL_W'(LAST_SOLO);
  assign frame_bits = fmt_bits(fmt_q);
  assign last_bit   = (bit_q == frame_bits - BITCNT_W'(1));
  assign frame_end  = (state == SQ_XFER) && fall_tick && last_bit;
  assign wrap       = (ch_q == last_ch);
  assign ch_next    = wrap ? '0 : ch_q + SEL_W'(1);

  assign run        = (state == SQ_XFER);
  assign sel_en_n   = (state != SQ_XFER);
  assign sel        = ch_q;
  assign wr_en      = frame_end;
  assign wr_addr    = ch_q;
  assign round_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      fmt_q  <= FMT_SOLO16;
      ch_q   <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= frame_end && wrap;
      case (state)
        SQ_IDLE: begin
          ch_q  <= '0;
          bit_q <= '0;
          if (enable) begin
            fmt_q <= frame_fmt_t'(mode);
            state <= SQ_XFER;
          end
        end
        SQ_XFER: begin
          if (fall_tick) begin
            if (last_bit) begin
              bit_q <= '0;
              state <= SQ_GAP;
            end else begin
              bit_q <= bit_q + BITCNT_W'(1);
            end
          end
        end
        SQ_GAP: begin
          if (enable) begin
            ch_q  <= ch_next;
            if (wrap) fmt_q <= frame_fmt_t'(mode);
            state <= SQ_XFER;
          end else begin
            ch_q  <= '0;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R8: the pass-complete flag lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |=> !round_done);
  // R8: the pass-complete flag appears only with the selects released
  p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |-> sel_en_n);
  // R2: the channel code does not move inside a frame
  p_sel_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en_n && $past(!sel_en_n)) |-> $stable(sel));
  // R2: a pass started from idle opens on channel 0
  p_start_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sel_en_n) && ($past(state) == SQ_IDLE)) |-> (sel == '0));
  // R5: the quad framing never raises the top select line
  p_quad_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en_n && fmt_is_quad(fmt_q)) |-> (int'(sel) <= int'(LAST_QUAD)));
  // R10: the framing in force does not change inside a frame
  p_fmt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en_n && $past(!sel_en_n)) |-> $stable(fmt_q));
  // R11: the gap between frames is a single cycle
  p_gap_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_GAP) |=> (state != SQ_GAP));

endmodule

// File: rtl/rr_adc_sampler.sv
module rr_adc_sampler #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CLK_DIV = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [1:0]               mode,
  input  logic                     miso,
  output logic                     sclk,
  output logic [2:0]               sel,
  output logic                     sel_en_n,
  output logic [NUM_CH*DATA_W-1:0] result_flat,
  output logic                     round_done
);
  localparam int unsigned SEL_W = 3;

  logic              run;
  logic              rise_tick;
  logic              fall_tick;
  logic              wr_en;
  logic [SEL_W-1:0]  wr_addr;
  logic [DATA_W-1:0] word;

  rr_channel_seq #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .mode       (mode),
    .fall_tick  (fall_tick),
    .run        (run),
    .sel        (sel),
    .sel_en_n   (sel_en_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .round_done (round_done)
  );

  rr_sclk_div #(.DIV(CLK_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  rr_frame_shift #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!run),
    .take  (rise_tick),
    .din   (miso),
    .word  (word)
  );

  rr_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (word),
    .result_flat (result_flat)
  );

  // R6: serial clock edges occur only with a converter selected
  p_rise_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !sel_en_n);
  // R9: when idle and not enabled, the selects stay released
  p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en_n && !enable) |=> sel_en_n);

endmodule

// File: tb/rr_adc_sampler_test.sv
module rr_adc_sampler_test;
  localparam int NCH = 8;
  localparam int DW  = 16;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'd2;
  logic miso = 1'b0;
  logic sclk, sel_en_n, round_done;
  logic [2:0] sel;
  logic [NCH*DW-1:0] result_flat;

  always #4 clk = ~clk;

  rr_adc_sampler #(.NUM_CH(NCH), .DATA_W(DW), .CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .miso(miso),
    .sclk(sclk), .sel(sel), .sel_en_n(sel_en_n),
    .result_flat(result_flat), .round_done(round_done)
  );

  int checks = 0;
  int fails = 0;
  logic [15:0] adc_val [NCH];

  // converter model: drives MSB first, next bit after each serial clock fall
  logic [15:0] sh = '0;
  logic prev_en_n = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;
  int rises = 0, last_rises = 0, hi_cnt = 0, last_gap = 0;
  int frames = 0, done_cnt = 0, done_twin = 0, sel_hi_cnt = 0;
  int seq_log [256];

  always @(negedge clk) begin
    if (!sel_en_n && sel[2]) sel_hi_cnt++;
    if (prev_en_n && !sel_en_n) begin
      sh = adc_val[sel];
      miso <= sh[15];
      seq_log[frames % 256] = int'(sel);
      last_gap = hi_cnt;
      rises = 0;
    end else if (!sel_en_n && prev_sclk && !sclk) begin
      sh = {sh[14:0], 1'b0};
      miso <= sh[15];
    end
    if (!sel_en_n && !prev_sclk && sclk) rises++;
    if (!prev_en_n && sel_en_n) begin
      last_rises = rises;
      frames++;
    end
    hi_cnt = sel_en_n ? hi_cnt + 1 : 0;
    if (round_done) begin
      done_cnt++;
      if (prev_done) done_twin++;
    end
    prev_en_n = sel_en_n;
    prev_sclk = sclk;
    prev_done = round_done;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] res(input int ch);
    return result_flat[ch*DW +: DW];
  endfunction

  function automatic logic [15:0] cut(input logic [15:0] v, input int bits);
    return v >> (16 - bits);
  endfunction

  task automatic set_vals(input int seed);
    for (int i = 0; i < NCH; i++)
      adc_val[i] = 16'((seed * 16'h3A7 + i * 16'h1D35) ^ 16'h8421);
  endtask

  task automatic wait_done();
    @(posedge round_done);
    @(negedge clk);
    #1;
  endtask

  task automatic stop_run();
    enable = 1'b0;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "sel_en_n", 32'(sel_en_n), 32'd1);
    chk("R1", "sclk", 32'(sclk), 32'd0);
    chk("R1", "sel", 32'(sel), 32'd0);
    chk("R1", "round_done", 32'(round_done), 32'd0);
    chk("R1", "results", 32'(result_flat != '0), 32'd0);
  endtask

  task automatic t_solo16();
    int base, dbase;
    set_vals(1);
    base = frames; dbase = done_cnt;
    mode = 2'd2; enable = 1'b1;
    wait_done();
    for (int i = 0; i < NCH; i++) begin
      chk("R3", $sformatf("ch%0d value", i), 32'(res(i)), 32'(adc_val[i]));
      chk("R2", $sformatf("order slot %0d", i), 32'(seq_log[(base + i) % 256]), 32'(i));
    end
    chk("R6", "rises per 16-bit frame", 32'(last_rises), 32'd16);
    chk("R11", "gap cycles", 32'(last_gap), 32'd1);
    chk("R8", "pulses in pass", 32'(done_cnt - dbase), 32'd1);
    stop_run();
    chk("R8", "pulse longer than one cycle", 32'(done_twin), 32'd0);
    chk("R3", "frames in pass", 32'(frames - base), 32'd8);
  endtask

  task automatic t_solo15();
    set_vals(2);
    mode = 2'd1; enable = 1'b1;
    wait_done();
    for (int i = 0; i < NCH; i++)
      chk("R4", $sformatf("ch%0d value", i), 32'(res(i)), 32'(cut(adc_val[i], 15)));
    chk("R6", "rises per 15-bit frame", 32'(last_rises), 32'd15);
    stop_run();
  endtask

  task automatic t_quad12();
    logic [15:0] prev [NCH];
    int base, hbase;
    for (int i = 0; i < NCH; i++) prev[i] = cut(adc_val[i], 15);
    set_vals(3);
    base = frames; hbase = sel_hi_cnt;
    mode = 2'd0; enable = 1'b1;
    wait_done();
    wait_done();
    for (int i = 0; i < 4; i++)
      chk("R5", $sformatf("ch%0d value", i), 32'(res(i)), 32'(cut(adc_val[i], 12)));
    for (int i = 4; i < NCH; i++)
      chk("R5", $sformatf("ch%0d untouched", i), 32'(res(i)), 32'(prev[i]));
    chk("R5", "frames in two passes", 32'(frames - base), 32'd8);
    chk("R5", "wrap after ch3", 32'(seq_log[(base + 4) % 256]), 32'd0);
    chk("R5", "sel[2] raised", 32'(sel_hi_cnt - hbase), 32'd0);
    chk("R6", "rises per 12-bit frame", 32'(last_rises), 32'd12);
    stop_run();
  endtask

  task automatic t_midframe_stop();
    logic [15:0] old0, old1;
    int fbase;
    old0 = res(0); old1 = res(1);
    set_vals(4);
    mode = 2'd2; enable = 1'b1;
    @(negedge sel_en_n);
    repeat (20) @(negedge clk);
    #1;
    chk("R7", "ch0 held during frame", 32'(res(0)), 32'(old0));
    enable = 1'b0;
    @(posedge sel_en_n);
    @(negedge clk);
    #1;
    chk("R9", "ch0 stored after stop", 32'(res(0)), 32'(adc_val[0]));
    chk("R9", "stopped frame length", 32'(last_rises), 32'd16);
    fbase = frames;
    repeat (30) @(negedge clk);
    #1;
    chk("R9", "sel_en_n idle", 32'(sel_en_n), 32'd1);
    chk("R9", "sclk idle", 32'(sclk), 32'd0);
    chk("R9", "sel idle", 32'(sel), 32'd0);
    chk("R9", "no further frames", 32'(frames - fbase), 32'd0);
    chk("R7", "ch1 untouched", 32'(res(1)), 32'(old1));
  endtask

  task automatic t_mode_switch();
    int base;
    set_vals(5);
    base = frames;
    mode = 2'd3; enable = 1'b1;
    @(posedge sel_en_n);
    #1;
    mode = 2'd0;
    wait_done();
    chk("R10", "frames in first pass", 32'(frames - base), 32'd8);
    chk("R10", "ch7 full width", 32'(res(7)), 32'(adc_val[7]));
    chk("R3", "mode 3 frame length", 32'(last_rises), 32'd16);
    wait_done();
    chk("R10", "frames after switch", 32'(frames - base), 32'd12);
    chk("R10", "ch0 narrow", 32'(res(0)), 32'(cut(adc_val[0], 12)));
    chk("R10", "ch3 narrow", 32'(res(3)), 32'(cut(adc_val[3], 12)));
    chk("R10", "second pass starts at 0", 32'(seq_log[(base + 8) % 256]), 32'd0);
    chk("R10", "narrow frame length", 32'(last_rises), 32'd12);
    stop_run();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) adc_val[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_solo16();
    t_solo15();
    t_quad12();
    t_midframe_stop();
    t_mode_switch();
    summary();
    $finish;
  end

endmodule